// File: doc/BRIEF.md
# Radio frame CRC append and check

This block sits in the byte path of a 2.4 GHz low-rate wireless transceiver, between the packet FIFOs and the modem. Every frame on the air starts with a length byte, followed by the MAC bytes. The last two MAC bytes hold a 16-bit frame check sequence over the polynomial x^16 + x^12 + x^5 + 1. The block handles those two bytes in both directions, so the FIFOs never hold them.

On transmit, the modem asks for one byte per slot strobe. The block pops the length byte and the payload from a show-ahead TX FIFO and runs the CRC over the payload. When the byte count reaches the last two positions, it sends the CRC from its own internal register and does not pop the FIFO. On receive, the block runs the CRC over every incoming MAC byte, including the two check bytes. In place of those two bytes it passes on two status bytes. The first is the RSSI sideband value. The second is a CRC-good flag above the 7-bit average correlation sideband value. A single enable turns all of this off, and the bytes then pass through untouched.

Top module: `frame_crc_proc`

## Requirements
- R1: The two transmitted check bytes are the CRC of the payload bytes. The CRC uses polynomial x^16+x^12+x^5+1, a start value of 0x0000, and bits fed least significant first (reflected constant 0x8408). The low byte is sent first, then the high byte.
- R2: The first byte of every frame is the length byte. It is forwarded unchanged in both directions and is not part of the CRC. Only bits 6:0 give the length, and bit 7 does not affect the byte count.
- R3: The length counts the MAC bytes, including the two check bytes. With the CRC enabled, a transmitted frame carries the length byte, then length-2 payload bytes from the FIFO, then the two check bytes.
- R4: The TX FIFO is not popped while the two check bytes are sent. A transmit frame with the CRC enabled pops exactly length-1 bytes. With the CRC disabled, it pops length+1 bytes.
- R5: Each cycle with `tx_slot` high produces exactly one byte on `tx_out_data`, with `tx_out_valid` high in the next cycle. `tx_fifo_pop` is never high without `tx_slot`.
- R6: With the CRC enabled, the output byte in place of the first received check byte equals `rx_rssi`.
- R7: With the CRC enabled, bits 6:0 of the output byte in place of the second received check byte equal `rx_corr`.
- R8: Bit 7 of that second status byte is 1 when the CRC register over all MAC bytes, check bytes included, ends at zero. It is 0 for a frame with a corrupted byte.
- R9: With the CRC disabled, every byte of a frame passes unchanged in both directions, one cycle later.
- R10: `crc_auto_en` is sampled at the length byte and holds for the whole frame. Changes during the frame have no effect on that frame.
- R11: While reset is asserted, both output valids are low. After reset, the next input byte is treated as a length byte, even if a frame was cut short.
- R12: Frames may follow back to back with no idle cycle. Each frame's CRC starts again from 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| crc_auto_en | input | 1 | Enables CRC insertion and checking; sampled per frame |
| tx_slot | input | 1 | Modem requests the next transmit byte |
| tx_fifo_data | input | 8 | Head byte of the show-ahead TX FIFO |
| tx_fifo_pop | output | 1 | Consumes the TX FIFO head byte this cycle |
| tx_out_valid | output | 1 | Transmit byte valid |
| tx_out_data | output | 8 | Transmit byte to modem |
| rx_in_valid | input | 1 | Received byte valid |
| rx_in_data | input | 8 | Received byte from modem |
| rx_rssi | input | 8 | Signal strength value for the current frame |
| rx_corr | input | 7 | Average correlation value for the current frame |
| rx_out_valid | output | 1 | Byte valid toward the RX FIFO |
| rx_out_data | output | 8 | Byte toward the RX FIFO |

## Verification
The bench builds the block with its default 7-bit length field and the standard reflected polynomial constant. With these values, frames of every length up to 127 and length bytes with bit 7 set can be reached. The bench runs zero-length, minimum two-byte and longer frames in both directions. It covers corrupted receive frames and frames that toggle the enable mid-frame. It also runs a reset that lands in the middle of a receive frame.

// File: rtl/frame_crc_pkg.sv
package frame_crc_pkg;
  localparam int BYTE_W = 8;
  localparam int CRC_W  = 16;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [CRC_W-1:0]  crc_t;

  // One byte through the reflected shift register, bit 0 first.
  function automatic crc_t crc_step(input crc_t c, input byte_t d, input crc_t poly_rev);
    crc_t r;
    r = c;
    for (int i = 0; i < BYTE_W; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ poly_rev;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/frame_crc_reg.sv
module frame_crc_reg
  import frame_crc_pkg::*;
#(
  parameter crc_t POLY_REV = 16'h8408
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  upd,
  input  byte_t din,
  output crc_t  crc_q,
  output crc_t  crc_nxt
);
  crc_t crc_d;

  always_comb begin
    crc_nxt = crc_step(crc_q, din, POLY_REV);
    crc_d   = crc_q;
    if (clr)      crc_d = '0;
    else if (upd) crc_d = crc_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          crc_q <= '0;
    else if (clr || upd) crc_q <= crc_d;
  end
endmodule

// File: rtl/frame_tx_path.sv
module frame_tx_path
  import frame_crc_pkg::*;
#(
  parameter int   LEN_W    = 7,
  parameter crc_t POLY_REV = 16'h8408
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  auto_en,
  input  logic  slot,
  input  byte_t fifo_data,
  output logic  fifo_pop,
  output logic  out_valid,
  output byte_t out_data
);
  localparam logic [LEN_W-1:0] REM_ONE = LEN_W'(1);
  localparam logic [LEN_W-1:0] REM_TWO = LEN_W'(2);

  logic             busy_q, busy_d, auto_q, auto_d, valid_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  byte_t            data_d;
  logic             crc_clr, crc_upd, in_check;
  crc_t             crc_q, crc_nxt;

  frame_crc_reg #(.POLY_REV(POLY_REV)) u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .upd(crc_upd),
    .din(fifo_data), .crc_q(crc_q), .crc_nxt(crc_nxt)
  );

  assign in_check = busy_q && auto_q && (rem_q <= REM_TWO);
  assign fifo_pop = slot && !in_check;

  always_comb begin
    busy_d  = busy_q;
    auto_d  = auto_q;
    rem_d   = rem_q;
    data_d  = out_data;
    valid_d = slot;
    crc_clr = 1'b0;
    crc_upd = 1'b0;
    if (slot) begin
      if (!busy_q) begin
        data_d  = fifo_data;
        rem_d   = fifo_data[LEN_W-1:0];
        auto_d  = auto_en;
        busy_d  = (fifo_data[LEN_W-1:0] != '0);
        crc_clr = 1'b1;
      end else begin
        if (in_check) begin
          data_d = (rem_q == REM_TWO) ? crc_q[7:0] : crc_q[15:8];
        end else begin
          data_d  = fifo_data;
          crc_upd = auto_q;
        end
        rem_d  = rem_q - REM_ONE;
        busy_d = (rem_q != REM_ONE);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      auto_q    <= 1'b0;
      rem_q     <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= valid_d;
      if (slot) begin
        busy_q   <= busy_d;
        auto_q   <= auto_d;
        rem_q    <= rem_d;
        out_data <= data_d;
      end
    end
  end

  // R5: a pop only ever accompanies a slot request
  p_pop_only_on_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> slot);
  // R5: every slot yields a valid byte in the next cycle
  p_slot_gives_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    slot |=> out_valid);
  // R4: the check sequence register holds while its bytes are being sent
  p_crc_hold_in_check_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot && in_check) |=> $stable(crc_q));
  // R12: a new frame starts the CRC from zero
  p_crc_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (slot && !busy_q) |=> (crc_q == '0));
endmodule

// File: rtl/frame_rx_path.sv
module frame_rx_path
  import frame_crc_pkg::*;
#(
  parameter int   LEN_W    = 7,
  parameter crc_t POLY_REV = 16'h8408
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_en,
  input  logic              in_valid,
  input  byte_t             in_data,
  input  byte_t             rssi,
  input  logic [BYTE_W-2:0] corr,
  output logic              out_valid,
  output byte_t             out_data
);
  localparam logic [LEN_W-1:0] REM_ONE = LEN_W'(1);
  localparam logic [LEN_W-1:0] REM_TWO = LEN_W'(2);

  logic             busy_q, busy_d, auto_q, auto_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  byte_t            data_d;
  logic             crc_clr, crc_upd, in_check;
  crc_t             crc_q, crc_nxt;

  frame_crc_reg #(.POLY_REV(POLY_REV)) u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .upd(crc_upd),
    .din(in_data), .crc_q(crc_q), .crc_nxt(crc_nxt)
  );

  assign in_check = busy_q && auto_q && (rem_q <= REM_TWO);

  always_comb begin
    busy_d  = busy_q;
    auto_d  = auto_q;
    rem_d   = rem_q;
    data_d  = out_data;
    crc_clr = 1'b0;
    crc_upd = 1'b0;
    if (in_valid) begin
      if (!busy_q) begin
        data_d  = in_data;
        rem_d   = in_data[LEN_W-1:0];
        auto_d  = auto_en;
        busy_d  = (in_data[LEN_W-1:0] != '0);
        crc_clr = 1'b1;
      end else begin
        crc_upd = auto_q;
        if (in_check)
          data_d = (rem_q == REM_TWO) ? rssi : {(crc_nxt == '0), corr};
        else
          data_d = in_data;
        rem_d  = rem_q - REM_ONE;
        busy_d = (rem_q != REM_ONE);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      auto_q    <= 1'b0;
      rem_q     <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        busy_q   <= busy_d;
        auto_q   <= auto_d;
        rem_q    <= rem_d;
        out_data <= data_d;
      end
    end
  end

  // R9: bytes outside the check positions leave unchanged one cycle later
  p_pass_through_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_check) |=> (out_valid && out_data == $past(in_data)));
  // R6: first check position becomes the signal strength byte
  p_rssi_subst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_check && rem_q == REM_TWO) |=> (out_data == $past(rssi)));
  // R9: with checking off the CRC register does not move
  p_crc_idle_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && busy_q && !auto_q) |=> $stable(crc_q));
endmodule

// File: rtl/frame_crc_proc.sv
module frame_crc_proc
  import frame_crc_pkg::*;
#(
  parameter int   LEN_W    = 7,
  parameter crc_t POLY_REV = 16'h8408
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              crc_auto_en,
  input  logic              tx_slot,
  input  logic [BYTE_W-1:0] tx_fifo_data,
  output logic              tx_fifo_pop,
  output logic              tx_out_valid,
  output logic [BYTE_W-1:0] tx_out_data,
  input  logic              rx_in_valid,
  input  logic [BYTE_W-1:0] rx_in_data,
  input  logic [BYTE_W-1:0] rx_rssi,
  input  logic [BYTE_W-2:0] rx_corr,
  output logic              rx_out_valid,
  output logic [BYTE_W-1:0] rx_out_data
);
  logic rst_meta, rst_sync;

  // Assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  frame_tx_path #(.LEN_W(LEN_W), .POLY_REV(POLY_REV)) u_tx (
    .clk(clk), .rst_n(rst_sync), .auto_en(crc_auto_en), .slot(tx_slot),
    .fifo_data(tx_fifo_data), .fifo_pop(tx_fifo_pop),
    .out_valid(tx_out_valid), .out_data(tx_out_data)
  );

  frame_rx_path #(.LEN_W(LEN_W), .POLY_REV(POLY_REV)) u_rx (
    .clk(clk), .rst_n(rst_sync), .auto_en(crc_auto_en), .in_valid(rx_in_valid),
    .in_data(rx_in_data), .rssi(rx_rssi), .corr(rx_corr),
    .out_valid(rx_out_valid), .out_data(rx_out_data)
  );

  // R11: no output byte is flagged while reset is held
  p_quiet_in_reset_r11: assert property (@(posedge clk)
    !rst_sync |-> (!tx_out_valid && !rx_out_valid));
endmodule

// File: tb/test_frame_crc_proc.sv
module test_frame_crc_proc;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W      = 7;
  localparam int NVEC       = 10;

  logic       clk, rst_n, crc_auto_en, tx_slot, tx_fifo_pop, tx_out_valid;
  logic [7:0] tx_fifo_data, tx_out_data, rx_in_data, rx_rssi, rx_out_data;
  logic [6:0] rx_corr;
  logic       rx_in_valid, rx_out_valid;

  int n_chk = 0;
  int n_fail = 0;

  frame_crc_proc #(.LEN_W(LEN_W)) i_frame_crc_proc (
    .clk(clk), .rst_n(rst_n), .crc_auto_en(crc_auto_en),
    .tx_slot(tx_slot), .tx_fifo_data(tx_fifo_data), .tx_fifo_pop(tx_fifo_pop),
    .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data),
    .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data), .rx_rssi(rx_rssi),
    .rx_corr(rx_corr), .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Show-ahead TX FIFO model
  logic [7:0] fmem [256];
  logic [7:0] wr_ptr, rd_ptr;
  assign tx_fifo_data = fmem[rd_ptr];
  always @(posedge clk or negedge rst_n)
    if (!rst_n) rd_ptr <= 8'd0;
    else if (tx_fifo_pop) rd_ptr <= rd_ptr + 8'd1;

  // Vector: [31] rx, [30] crc on, [29] corrupt, [23:16] length byte, [15:8] seed, [7:0] rssi
  localparam logic [31:0] VEC [NVEC] = '{
    32'h4005_01_33,  // tx, len 5
    32'h400C_3C_00,  // tx, len 12, back to back
    32'h0004_77_00,  // tx, crc off
    32'h4002_10_00,  // tx, len 2: check bytes only
    32'hC007_22_C4,  // rx, len 7
    32'hE009_45_80,  // rx, corrupted
    32'h8005_9A_11,  // rx, crc off
    32'hC086_05_7F,  // rx, length byte bit 7 set
    32'hC000_00_AA,  // rx, zero length
    32'h4084_61_00   // tx, length byte bit 7 set
  };

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int b = 0; b < 8; b++) begin
      if (r[0] != d[b]) r = {1'b0, r[15:1]} ^ 16'h8408;
      else              r = {1'b0, r[15:1]};
    end
    return r;
  endfunction

  function automatic logic [7:0] pay(input logic [7:0] seed, input int i);
    return 8'(int'(seed) * 37 + i * 11 + 92);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_tx(input logic [7:0] lb, input logic [7:0] seed, input bit auto_on, input bit flip);
    int len, npay;
    logic [7:0]  ex [0:130];
    string       tg [0:130];
    logic [15:0] c;
    logic [7:0]  start;
    len  = int'(lb[6:0]);
    npay = auto_on ? ((len >= 2) ? len - 2 : 0) : len;
    c = 16'h0000;
    fmem[wr_ptr] = lb; wr_ptr = wr_ptr + 8'd1;
    ex[0] = lb; tg[0] = "R2 length byte";
    for (int i = 1; i <= npay; i++) begin
      ex[i] = pay(seed, i);
      tg[i] = auto_on ? "R3 payload" : "R9 bypass byte";
      fmem[wr_ptr] = ex[i]; wr_ptr = wr_ptr + 8'd1;
      c = ref_crc(c, ex[i]);
    end
    if (auto_on && len >= 2) begin
      ex[len-1] = c[7:0];  tg[len-1] = flip ? "R10 crc low" : "R1 R12 crc low";
      ex[len]   = c[15:8]; tg[len]   = flip ? "R10 crc high" : "R1 R12 crc high";
    end
    start = rd_ptr;
    @(negedge clk);
    crc_auto_en = auto_on;
    tx_slot = 1'b1;
    for (int k = 0; k <= len; k++) begin
      @(negedge clk);
      if (k == 0 && flip) crc_auto_en = !auto_on;
      chk(tx_out_valid && tx_out_data == ex[k], tg[k], {tx_out_valid, tx_out_data}, {1'b1, ex[k]});
      if (k == len) tx_slot = 1'b0;
    end
    chk(8'(rd_ptr - start) == 8'(npay + 1), "R4 pops per frame", rd_ptr - start, npay + 1);
    @(negedge clk);
    chk(!tx_out_valid, "R5 no byte without slot", tx_out_valid, 0);
  endtask

  task automatic run_rx(input logic [7:0] lb, input logic [7:0] seed, input bit auto_on,
                        input bit corrupt, input logic [7:0] rssi);
    int len, npay;
    logic [7:0]  sd [0:130];
    logic [7:0]  ex [0:130];
    string       tg [0:130];
    logic [15:0] c;
    logic [6:0]  cv;
    len  = int'(lb[6:0]);
    npay = auto_on ? ((len >= 2) ? len - 2 : 0) : len;
    cv = seed[6:0] ^ 7'h2a;
    c = 16'h0000;
    sd[0] = lb; ex[0] = lb; tg[0] = "R2 length byte";
    for (int i = 1; i <= npay; i++) begin
      sd[i] = pay(seed, i);
      c = ref_crc(c, sd[i]);
    end
    if (auto_on && len >= 2) begin
      sd[len-1] = c[7:0];
      sd[len]   = c[15:8];
    end
    if (corrupt && npay >= 1) sd[1] = sd[1] ^ 8'h04;
    for (int i = 1; i <= npay; i++) begin
      ex[i] = sd[i];
      tg[i] = auto_on ? "R2 payload" : "R9 bypass byte";
    end
    if (auto_on && len >= 2) begin
      ex[len-1] = rssi;            tg[len-1] = "R6 rssi byte";
      ex[len]   = {!corrupt, cv};  tg[len]   = corrupt ? "R8 R7 bad crc status" : "R8 R7 good crc status";
    end
    @(negedge clk);
    crc_auto_en = auto_on;
    rx_rssi = rssi;
    rx_corr = cv;
    rx_in_valid = 1'b1;
    rx_in_data = sd[0];
    for (int k = 0; k <= len; k++) begin
      @(negedge clk);
      chk(rx_out_valid && rx_out_data == ex[k], tg[k], {rx_out_valid, rx_out_data}, {1'b1, ex[k]});
      if (k == len) rx_in_valid = 1'b0;
      else rx_in_data = sd[k+1];
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wr_ptr = 8'd0;
    repeat (3) @(negedge clk);
    chk(!tx_out_valid && !rx_out_valid, "R11 outputs idle in reset", {tx_out_valid, rx_out_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    crc_auto_en = 1'b1;
    tx_slot = 1'b0;
    rx_in_valid = 1'b0;
    rx_in_data = 8'h00;
    rx_rssi = 8'h00;
    rx_corr = 7'h00;
    wr_ptr = 8'd0;
    do_reset();

    // Table of frames, sent back to back (R12)
    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][31])
        run_rx(VEC[v][23:16], VEC[v][15:8], VEC[v][30], VEC[v][29], VEC[v][7:0]);
      else
        run_tx(VEC[v][23:16], VEC[v][15:8], VEC[v][30], 1'b0);
    end

    // R10: enable flips after the length byte; frame keeps its sampled mode
    run_tx(8'h06, 8'h2d, 1'b1, 1'b1);
    run_tx(8'h03, 8'h4e, 1'b0, 1'b1);

    // R11: reset lands in the middle of a receive frame
    @(negedge clk);
    crc_auto_en = 1'b1;
    rx_in_valid = 1'b1;
    rx_in_data = 8'h08;
    repeat (3) begin
      @(negedge clk);
      rx_in_data = 8'h3a;
    end
    rx_in_valid = 1'b0;
    do_reset();
    run_rx(8'h05, 8'h13, 1'b1, 1'b0, 8'h5d);  // R11 fresh frame after reset
    run_tx(8'h04, 8'h71, 1'b1, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule